// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block follows a chain of descriptor nodes held in word-addressed memory and forwards each node's payload to a device. A node starts with one header word. The top eight bits of the header give the number of payload words that follow. The low 24 bits give the byte address of the next node. The walker reads the header, sends the payload words to the device write port in ascending address order, and then moves to the next node. When a next pointer is all ones, the chain is finished.

Software, or a neighbouring controller, loads a start address and pulses `start`. The walker then runs by itself. It only fetches a new header while the device request input is high. If the request drops between nodes, the walk parks on the next node's address, shown on `base_out`, and carries on from there when the request returns. A running cost figure charges each header fetch and each non-empty node's setup, so that the owner of the bus can account for the time the chain used. A node that would read past the end of the RAM window aborts the walk and raises a bus-error pulse.

Top module: `ll_walker`

## Requirements
- R1: A header word is decoded with the payload count in bits 31..24 and the next node address in bits 23..0. The payload words are read from header+4, header+8, and so on, always stepping upward. They are delivered to the device port in that order, one word per accepted handshake.
- R2: A next pointer equal to 0xFFFFFF ends the walk. `done` is high for exactly one cycle and `busy` is low in that cycle. `base_out` reads 0xFFFFFF. The block is idle (busy low, no pulses) in the following cycle.
- R3: A node whose count field is zero costs exactly one memory read, which is its header. No device word is issued for it, and the walk continues at its next pointer.
- R4: The `cost` output is cleared when a walk starts. It then grows by 10 for every header fetched, plus a further 5 when that header's count is nonzero. It holds its value after the walk ends.
- R5: Every memory read address has bits 1..0 equal to zero. The node address is taken as 24 bits, and its two low bits are dropped before the header fetch.
- R6: While `dev_req` is low before a header fetch, no memory read is issued and `busy` stays high. `base_out` shows the address of the node still to be fetched. The walk resumes from that node once `dev_req` is high.
- R7: If the word-aligned node address plus 4 exceeds the RAM size (8 MiB by default), the header is not read. Instead `bus_err` pulses for one cycle, `busy` drops, `base_out` keeps the offending node address, and `done` does not pulse.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_addr` hold. While `dev_valid` is high and `dev_ready` is low, `dev_valid` and `dev_data` hold.
- R9: A `start` pulse while `busy` is high is ignored. The walk in progress finishes unchanged.
- R10: After reset, `busy`, `done`, `bus_err`, `rd_valid` and `dev_valid` are low, and `base_out` and `cost` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk at `base_in` (ignored while busy) |
| base_in | input | 24 | Address of the first node |
| dev_req | input | 1 | Device request; a header is fetched only while high |
| busy | output | 1 | Walk in progress or paused |
| done | output | 1 | One-cycle pulse when the terminator is reached |
| bus_err | output | 1 | One-cycle pulse when a node lies outside RAM |
| base_out | output | 24 | Current node address; 0xFFFFFF after completion |
| cost | output | 16 | Accumulated access cost of the current or last walk |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | 24 | Word-aligned memory byte address |
| rd_ready | input | 1 | Memory accepts the read; `rd_data` is valid in the same cycle |
| rd_data | input | 32 | Memory read word |
| dev_valid | output | 1 | Payload word offered to the device |
| dev_data | output | 32 | Payload word |
| dev_ready | input | 1 | Device accepts the offered word |

## Verification
The bound checker watches, on every cycle, that both handshakes hold their address or data while stalled and that read addresses stay word-aligned. It also checks that a completion pulse comes with the terminator on `base_out` and is followed by an idle cycle, and that an abort never coincides with completion while the parked address lies beyond RAM. Everything about the content of a walk can only be shown by the bench's chains: payload order, the word and read counts, the zero-length nodes, the cost totals, resuming after a dropped request, and a start pulse arriving mid-walk being ignored. Each chain is run against known memory contents, with and without back-pressure.

// File: rtl/ll_walker_pkg.sv
package ll_walker_pkg;

  // Walker sequencing states
  typedef enum logic [2:0] {
    W_IDLE,
    W_NEXT,       // gate on request and bounds before a header fetch
    W_FETCH_HDR,
    W_STREAM,     // payload read / device write alternation
    W_DONE,
    W_ERROR
  } walk_st_e;

endpackage

// File: rtl/ll_rst_sync.sv
module ll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end

endmodule

// File: rtl/ll_hdr_unpack.sv
module ll_hdr_unpack #(
  parameter int AW         = 24,
  parameter int CW         = 8,
  parameter int DW         = 32,
  parameter int COST_W     = 16,
  parameter int HDR_COST   = 10,
  parameter int SETUP_COST = 5
) (
  input  logic [DW-1:0]     word_i,
  output logic [CW-1:0]     cnt_o,
  output logic [AW-1:0]     next_o,
  output logic              term_o,
  output logic [COST_W-1:0] cost_o
);

  localparam logic [COST_W-1:0] EMPTY_COST = COST_W'(HDR_COST);
  localparam logic [COST_W-1:0] FULL_COST  = COST_W'(HDR_COST + SETUP_COST);

  assign cnt_o  = word_i[DW-1 -: CW];
  assign next_o = word_i[AW-1:0];
  assign term_o = &word_i[AW-1:0];
  assign cost_o = (cnt_o != '0) ? FULL_COST : EMPTY_COST;

endmodule

// File: rtl/ll_fetch_addr.sv
module ll_fetch_addr #(
  parameter int AW        = 24,
  parameter int RAM_BYTES = 32'h0080_0000
) (
  input  logic [AW-1:0] node_i,
  output logic [AW-1:0] hdr_addr_o,
  output logic [AW-1:0] pay0_o,
  output logic          oob_o
);

  localparam logic [AW:0]   RAM_LIM  = (AW+1)'(RAM_BYTES);
  localparam logic [AW-1:0] WORD_MSK = ~AW'(3);

  assign hdr_addr_o = node_i & WORD_MSK;
  assign pay0_o     = hdr_addr_o + AW'(4);
  assign oob_o      = ({1'b0, hdr_addr_o} + (AW+1)'(4)) > RAM_LIM;

endmodule

// File: rtl/ll_cost_acc.sv
module ll_cost_acc #(
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [COST_W-1:0] inc_i,
  output logic [COST_W-1:0] total_o
);

  logic [COST_W-1:0] total_d;
  logic              total_en;

  always_comb begin
    total_en = clr_i | add_i;
    total_d  = clr_i ? '0 : total_o + inc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_o <= '0;
    end else if (total_en) begin
      total_o <= total_d;
    end
  end

endmodule

// File: rtl/ll_walker.sv
module ll_walker #(
  parameter int AW         = 24,
  parameter int CW         = 8,
  parameter int DW         = 32,
  parameter int COST_W     = 16,
  parameter int HDR_COST   = 10,
  parameter int SETUP_COST = 5,
  parameter int RAM_BYTES  = 32'h0080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base_in,
  input  logic              dev_req,
  output logic              busy,
  output logic              done,
  output logic              bus_err,
  output logic [AW-1:0]     base_out,
  output logic [COST_W-1:0] cost,
  output logic              rd_valid,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ready,
  input  logic [DW-1:0]     rd_data,
  output logic              dev_valid,
  output logic [DW-1:0]     dev_data,
  input  logic              dev_ready
);

  import ll_walker_pkg::*;

  localparam logic [AW-1:0] TERM_ADDR = '1;
  localparam logic [CW-1:0] ONE_LEFT  = CW'(1);

  logic srst_n;

  walk_st_e      state_q, state_d;
  logic [AW-1:0] node_q, node_d;
  logic [AW-1:0] nxt_q;
  logic [CW-1:0] left_q, left_d;
  logic [AW-1:0] pay_q, pay_d;
  logic [DW-1:0] buf_q;
  logic          full_q, full_d;
  logic          node_en, hdr_ld, left_en, pay_en, buf_ld;
  logic          cost_clr, cost_add;

  logic [CW-1:0]     h_cnt;
  logic [AW-1:0]     h_next;
  logic              h_term;
  logic [COST_W-1:0] h_cost;
  logic [AW-1:0]     hdr_addr, pay0;
  logic              node_oob;

  ll_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ll_hdr_unpack #(
    .AW(AW), .CW(CW), .DW(DW), .COST_W(COST_W),
    .HDR_COST(HDR_COST), .SETUP_COST(SETUP_COST)
  ) u_hdr (
    .word_i (rd_data),
    .cnt_o  (h_cnt),
    .next_o (h_next),
    .term_o (h_term),
    .cost_o (h_cost)
  );

  ll_fetch_addr #(.AW(AW), .RAM_BYTES(RAM_BYTES)) u_addr (
    .node_i     (node_q),
    .hdr_addr_o (hdr_addr),
    .pay0_o     (pay0),
    .oob_o      (node_oob)
  );

  ll_cost_acc #(.COST_W(COST_W)) u_cost (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr_i   (cost_clr),
    .add_i   (cost_add),
    .inc_i   (h_cost),
    .total_o (cost)
  );

  // Next-state and datapath control
  always_comb begin
    state_d  = state_q;
    node_en  = 1'b0;
    node_d   = node_q;
    hdr_ld   = 1'b0;
    left_en  = 1'b0;
    left_d   = left_q;
    pay_en   = 1'b0;
    pay_d    = pay_q;
    buf_ld   = 1'b0;
    full_d   = full_q;
    cost_clr = 1'b0;
    cost_add = 1'b0;
    rd_valid = 1'b0;
    rd_addr  = pay_q;

    unique case (state_q)
      W_IDLE: begin
        if (start) begin
          node_en  = 1'b1;
          node_d   = base_in;
          cost_clr = 1'b1;
          state_d  = W_NEXT;
        end
      end

      W_NEXT: begin
        if (dev_req) begin
          state_d = node_oob ? W_ERROR : W_FETCH_HDR;
        end
      end

      W_FETCH_HDR: begin
        rd_valid = 1'b1;
        rd_addr  = hdr_addr;
        if (rd_ready) begin
          hdr_ld   = 1'b1;
          cost_add = 1'b1;
          left_en  = 1'b1;
          left_d   = h_cnt;
          pay_en   = 1'b1;
          pay_d    = pay0;
          full_d   = 1'b0;
          if (h_cnt == '0) begin
            node_en = 1'b1;
            node_d  = h_term ? TERM_ADDR : h_next;
            state_d = h_term ? W_DONE : W_NEXT;
          end else begin
            state_d = W_STREAM;
          end
        end
      end

      W_STREAM: begin
        if (!full_q) begin
          rd_valid = 1'b1;
          if (rd_ready) begin
            buf_ld = 1'b1;
            full_d = 1'b1;
            pay_en = 1'b1;
            pay_d  = pay_q + AW'(4);
          end
        end else if (dev_ready) begin
          full_d  = 1'b0;
          left_en = 1'b1;
          left_d  = left_q - ONE_LEFT;
          if (left_q == ONE_LEFT) begin
            node_en = 1'b1;
            node_d  = (&nxt_q) ? TERM_ADDR : nxt_q;
            state_d = (&nxt_q) ? W_DONE : W_NEXT;
          end
        end
      end

      W_DONE:  state_d = W_IDLE;
      W_ERROR: state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  // State and datapath registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= W_IDLE;
      node_q  <= '0;
      nxt_q   <= '0;
      left_q  <= '0;
      pay_q   <= '0;
      buf_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      full_q  <= full_d;
      if (node_en) node_q <= node_d;
      if (hdr_ld)  nxt_q  <= h_next;
      if (left_en) left_q <= left_d;
      if (pay_en)  pay_q  <= pay_d;
      if (buf_ld)  buf_q  <= rd_data;
    end
  end

  assign busy      = (state_q == W_NEXT) || (state_q == W_FETCH_HDR) || (state_q == W_STREAM);
  assign done      = (state_q == W_DONE);
  assign bus_err   = (state_q == W_ERROR);
  assign base_out  = node_q;
  assign dev_valid = (state_q == W_STREAM) && full_q;
  assign dev_data  = buf_q;

endmodule

// File: rtl/ll_walker_chk.sv
module ll_walker_chk #(
  parameter int AW        = 24,
  parameter int DW        = 32,
  parameter int RAM_BYTES = 32'h0080_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          bus_err,
  input logic [AW-1:0] base_out,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ready,
  input logic          dev_valid,
  input logic [DW-1:0] dev_data,
  input logic          dev_ready
);

  localparam logic [AW:0] RAM_LIM = (AW+1)'(RAM_BYTES);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R8
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_data)));

  // R5
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[1:0] == 2'b00));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done && !bus_err));

  // R2
  done_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && (&base_out)));

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!done && !busy));

  // R7
  err_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (({1'b0, base_out[AW-1:2], 2'b00} + (AW+1)'(4)) > RAM_LIM));

endmodule

bind ll_walker ll_walker_chk #(.AW(AW), .DW(DW), .RAM_BYTES(RAM_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .bus_err   (bus_err),
  .base_out  (base_out),
  .rd_valid  (rd_valid),
  .rd_addr   (rd_addr),
  .rd_ready  (rd_ready),
  .dev_valid (dev_valid),
  .dev_data  (dev_data),
  .dev_ready (dev_ready)
);

// File: tb/sim_ll_walker.sv
module sim_ll_walker;

  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [23:0] base;
    logic [7:0]  words;
    logic [31:0] wx;
    logic [15:0] cst;
    logic [7:0]  reads;
    logic [23:0] endb;
    logic        err;
    logic        rstall;
    logic        dstall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{24'h000000, 8'd3, 32'hD000_0088, 16'd40, 8'd6, 24'hFFFFFF, 1'b0, 1'b0, 1'b0},
    '{24'h000100, 8'd3, 32'hD000_0100, 16'd15, 8'd4, 24'hFFFFFF, 1'b0, 1'b0, 1'b1},
    '{24'h000200, 8'd0, 32'h0000_0000, 16'd10, 8'd1, 24'hFFFFFF, 1'b0, 1'b0, 1'b0},
    '{24'h000300, 8'd1, 32'hD000_0304, 16'd25, 8'd3, 24'h800000, 1'b1, 1'b0, 1'b0},
    '{24'h000003, 8'd3, 32'hD000_0088, 16'd40, 8'd6, 24'hFFFFFF, 1'b0, 1'b0, 1'b0},
    '{24'h7FFFFC, 8'd0, 32'h0000_0000, 16'd10, 8'd1, 24'hFFFFFF, 1'b0, 1'b0, 1'b0},
    '{24'h800000, 8'd0, 32'h0000_0000, 16'd0,  8'd0, 24'h800000, 1'b1, 1'b0, 1'b0},
    '{24'h000000, 8'd3, 32'hD000_0088, 16'd40, 8'd6, 24'hFFFFFF, 1'b0, 1'b1, 1'b1},
    '{24'h000300, 8'd1, 32'hD000_0304, 16'd25, 8'd3, 24'h800000, 1'b1, 1'b1, 1'b1}
  };

  logic        clk, rst_n, start, dev_req;
  logic [23:0] base_in;
  logic        busy, done, bus_err;
  logic [23:0] base_out;
  logic [15:0] cost;
  logic        rd_valid, rd_ready;
  logic [23:0] rd_addr;
  logic [31:0] rd_data;
  logic        dev_valid, dev_ready;
  logic [31:0] dev_data;

  logic [31:0] mem [256];
  logic        rstall, dstall;
  int          cyc, nreads, nwords, nchecks, nerrors;
  logic [31:0] wxor;

  ll_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in), .dev_req(dev_req),
    .busy(busy), .done(done), .bus_err(bus_err), .base_out(base_out), .cost(cost),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  assign rd_data = mem[rd_addr[9:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_valid && rd_ready) nreads <= nreads + 1;
    if (dev_valid && dev_ready) begin
      nwords <= nwords + 1;
      wxor   <= wxor ^ dev_data;
    end
  end

  always @(negedge clk) begin
    rd_ready  <= rstall ? cyc[0] : 1'b1;
    dev_ready <= dstall ? cyc[1] : 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [23:0] b);
    @(negedge clk);
    base_in = b;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic wait_end(output logic sd, output logic se);
    sd = 1'b0;
    se = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (done || bus_err) begin
        sd = done;
        se = bus_err;
        break;
      end
    end
    if (!sd && !se) chk(1'b0, "R2 timeout waiting for end", 0, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 | (i << 2);
    mem[8'h00] = {8'd2, 24'h000040};
    mem[8'h10] = {8'd0, 24'h000080};
    mem[8'h20] = {8'd1, 24'hFFFFFF};
    mem[8'h40] = {8'd3, 24'hFFFFFF};
    mem[8'h80] = {8'd0, 24'hFFFFFF};
    mem[8'hC0] = {8'd1, 24'h0003F0};
    mem[8'hFC] = {8'd0, 24'h800000};
    mem[8'hFF] = {8'd0, 24'hFFFFFF};
  end

  initial begin
    logic sd, se;
    int   r0, w0;
    logic [31:0] x0;
    cyc = 0; nreads = 0; nwords = 0; wxor = '0; nchecks = 0; nerrors = 0;
    rst_n = 1'b0; start = 1'b0; base_in = '0; dev_req = 1'b1;
    rstall = 1'b0; dstall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(!busy && !done && !bus_err, "R10 flags", {busy, done, bus_err}, 0);
    chk(!rd_valid && !dev_valid, "R10 handshakes", {rd_valid, dev_valid}, 0);
    chk(base_out == 24'h0 && cost == 16'h0, "R10 base/cost", {base_out, cost[7:0]}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      rstall = TBL[i].rstall;
      dstall = TBL[i].dstall;
      r0 = nreads; w0 = nwords; x0 = wxor;
      pulse_start(TBL[i].base);
      wait_end(sd, se);
      chk(se == TBL[i].err && sd == !TBL[i].err, TBL[i].err ? "R7 abort pulse" : "R2 done pulse",
          {sd, se}, {!TBL[i].err, TBL[i].err});
      chk(!busy, "R2 busy low at end", busy, 0);
      chk(base_out == TBL[i].endb, TBL[i].err ? "R7 parked address" : "R2 terminator base",
          base_out, TBL[i].endb);
      @(negedge clk);
      chk(!busy && !done && !bus_err, "R2 idle after end", {busy, done, bus_err}, 0);
      chk((nwords - w0) == int'(TBL[i].words), TBL[i].rstall ? "R8 words under stall" : "R1 word count",
          nwords - w0, TBL[i].words);
      chk((wxor ^ x0) == TBL[i].wx, TBL[i].base[1:0] != 0 ? "R5 unaligned start data" : "R1 payload data",
          wxor ^ x0, TBL[i].wx);
      chk((nreads - r0) == int'(TBL[i].reads), "R3 read count", nreads - r0, TBL[i].reads);
      chk(cost == TBL[i].cst, "R4 cost", cost, TBL[i].cst);
    end
    rstall = 1'b0;
    dstall = 1'b0;

    // R6 request low before the first header
    dev_req = 1'b0;
    r0 = nreads;
    pulse_start(24'h000200);
    repeat (10) @(negedge clk);
    chk(busy, "R6 busy while parked", busy, 1);
    chk(nreads == r0, "R6 no read while parked", nreads - r0, 0);
    chk(base_out == 24'h000200, "R6 parked base", base_out, 24'h000200);
    dev_req = 1'b1;
    wait_end(sd, se);
    chk(sd, "R6 resume completes", sd, 1);

    // R6 request drop between nodes, R9 start while busy
    r0 = nreads; w0 = nwords; x0 = wxor;
    pulse_start(24'h000000);
    for (int k = 0; k < 200; k++) begin
      if (dev_valid && dev_ready) break;
      @(negedge clk);
    end
    dev_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy, "R6 busy between nodes", busy, 1);
    chk(base_out == 24'h000040, "R6 saved next node", base_out, 24'h000040);
    chk((nwords - w0) == 2, "R6 words before pause", nwords - w0, 2);
    chk((nreads - r0) == 3, "R6 reads before pause", nreads - r0, 3);
    pulse_start(24'h000100);
    chk(base_out == 24'h000040, "R9 start ignored", base_out, 24'h000040);
    dev_req = 1'b1;
    wait_end(sd, se);
    chk(sd && base_out == 24'hFFFFFF, "R9 walk finished", base_out, 24'hFFFFFF);
    chk((nwords - w0) == 3 && (wxor ^ x0) == 32'hD000_0088, "R9 original chain data",
        wxor ^ x0, 32'hD000_0088);
    chk(cost == 16'd40, "R4 cost across pause", cost, 40);

    $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    nchecks++;
    nerrors++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
    $finish;
  end

endmodule